// File: doc/BRIEF.md
# Gray code successor counter

This block keeps an N-bit word in the reflected Gray sequence and, whenever it is told to advance, replaces that word with the one that follows it. It never counts in binary and never converts to or from binary. The next word comes from flipping exactly one bit, chosen from the parity of the current word and the position of its lowest set bit. A purely combinational successor path drives the `next_word` output at all times, so the word after the current one is always visible before the clock edge that would store it.

Each cycle a small selector chooses one of four register actions. The choices are listed from highest priority down:
- ACT_CLEAR, taken when `rst` is high. The stored word is set to all zeros.
- ACT_LOAD, taken when `load` is high. The stored word is set to `load_word`.
- ACT_STEP, taken when `en` is high. The stored word is set to the successor.
- ACT_HOLD, taken otherwise. The stored word does not change.

Every action can follow every other action, and each transition is decided by the inputs sampled at that edge alone. WIDTH defaults to 3 and must be at least 2.

Top module: `gray_step_counter`

## Requirements
- R1: When `rst` is high at a rising edge, `word` is all zeros after that edge, whatever `en` and `load` are.
- R2: `next_word` always equals the Gray successor of `word`. For WIDTH=3 the words run 000, 001, 011, 010, 110, 111, 101, 100 and then start again at 000.
- R3: `word` and `next_word` always differ in exactly one bit position.
- R4: When `en` is high and `load` is low (and `rst` is low), `word` takes the value `next_word` had before the edge.
- R5: When `load` is high (and `rst` is low), `word` takes `load_word` at the edge, even if `en` is also high.
- R6: When `en`, `load` and `rst` are all low, `word` keeps its value.
- R7: The word with only the MSB set (100 for WIDTH=3) is followed by all zeros.
- R8: Starting from zero, 2^WIDTH consecutive steps visit every word exactly once and return to zero.
- R9: If `word` has an even number of ones, bit 0 is the bit that flips. Otherwise the bit just above the lowest set bit flips.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst | input | 1 | Synchronous reset to zero, active high |
| en | input | 1 | Advance to the successor word |
| load | input | 1 | Store `load_word`; overrides `en` |
| load_word | input | WIDTH | Value stored when `load` is high |
| word | output | WIDTH | Current Gray word |
| next_word | output | WIDTH | Combinational successor of `word` |

## Verification
If the stored word is corrupted, the error appears on `word` after the next edge. The same error also appears at once on `next_word`, because that output is computed directly from the stored word. A wrong flip choice in the successor logic is visible in the same cycle, as a `next_word` that differs from `word` in zero or in several bits, or that disagrees with a binary-derived reference. A wrong choice of action (priority or hold) is visible one edge later as a `word` that differs from the value predicted from the inputs.

// File: rtl/gray_step_pkg.sv
package gray_step_pkg;

    typedef enum logic [1:0] {
        ACT_HOLD  = 2'd0,
        ACT_STEP  = 2'd1,
        ACT_LOAD  = 2'd2,
        ACT_CLEAR = 2'd3
    } step_act_e;

endpackage

// File: rtl/gray_step_select.sv
module gray_step_select
    import gray_step_pkg::*;
(
    input  logic      rst,
    input  logic      en,
    input  logic      load,
    output step_act_e act
);

    // Priority: clear, then load, then step, then hold.
    always_comb begin
        if (rst)       act = ACT_CLEAR;
        else if (load) act = ACT_LOAD;
        else if (en)   act = ACT_STEP;
        else           act = ACT_HOLD;
    end

endmodule

// File: rtl/gray_step_successor.sv
module gray_step_successor #(
    parameter int WIDTH = 3
) (
    input  logic [WIDTH-1:0] cur,
    output logic [WIDTH-1:0] nxt
);

    localparam int TOP = WIDTH - 1;

    logic             odd;
    logic [WIDTH-1:0] lowest;
    logic [WIDTH-1:0] flip;

    // Parity picks the rule. The one-hot lowest set bit is computed once
    // and shared by every flip position above bit 0.
    assign odd    = ^cur;
    assign lowest = cur & (~cur + WIDTH'(1));

    generate
        for (genvar b = 0; b < WIDTH; b++) begin : g_flip
            if (b == 0) begin : g_lsb
                assign flip[b] = ~odd;
            end else if (b == TOP) begin : g_msb
                // Above the lowest bit, or wrap when the MSB is the lowest bit.
                assign flip[b] = odd & (lowest[b-1] | lowest[b]);
            end else begin : g_mid
                assign flip[b] = odd & lowest[b-1];
            end
        end
    endgenerate

    assign nxt = cur ^ flip;

endmodule

// File: rtl/gray_step_register.sv
module gray_step_register
    import gray_step_pkg::*;
#(
    parameter int WIDTH = 3
) (
    input  logic             clk,
    input  step_act_e        act,
    input  logic [WIDTH-1:0] succ,
    input  logic [WIDTH-1:0] load_word,
    output logic [WIDTH-1:0] word
);

    always_ff @(posedge clk) begin
        unique case (act)
            ACT_CLEAR: word <= '0;
            ACT_LOAD:  word <= load_word;
            ACT_STEP:  word <= succ;
            ACT_HOLD:  word <= word;
        endcase
    end

endmodule

// File: rtl/gray_step_counter.sv
module gray_step_counter
    import gray_step_pkg::*;
#(
    parameter int WIDTH = 3
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             en,
    input  logic             load,
    input  logic [WIDTH-1:0] load_word,
    output logic [WIDTH-1:0] word,
    output logic [WIDTH-1:0] next_word
);

    step_act_e act;

    gray_step_select u_select (
        .rst  (rst),
        .en   (en),
        .load (load),
        .act  (act)
    );

    gray_step_successor #(.WIDTH(WIDTH)) u_successor (
        .cur (word),
        .nxt (next_word)
    );

    gray_step_register #(.WIDTH(WIDTH)) u_register (
        .clk       (clk),
        .act       (act),
        .succ      (next_word),
        .load_word (load_word),
        .word      (word)
    );

endmodule

// File: rtl/gray_step_counter_chk.sv
module gray_step_counter_chk #(
    parameter int WIDTH = 3
) (
    input logic             clk,
    input logic             rst,
    input logic             en,
    input logic             load,
    input logic [WIDTH-1:0] load_word,
    input logic [WIDTH-1:0] word,
    input logic [WIDTH-1:0] next_word
);

    localparam logic [WIDTH-1:0] MSB_ONLY = {1'b1, {(WIDTH-1){1'b0}}};

    logic armed = 1'b0;
    logic seen_rst = 1'b0;
    always_ff @(posedge clk) begin
        armed <= 1'b1;
        if (rst) seen_rst <= 1'b1;
    end

    AST_RESET_CLEARS: assert property (@(posedge clk) disable iff (!armed)
        $past(rst) |-> word == '0); // R1
    AST_ONE_BIT_STEP: assert property (@(posedge clk) disable iff (rst || !seen_rst)
        $countones(word ^ next_word) == 1); // R3
    AST_STEP_FOLLOWS: assert property (@(posedge clk) disable iff (rst || !seen_rst)
        (en && !load) |=> word == $past(next_word)); // R4
    AST_LOAD_WINS: assert property (@(posedge clk) disable iff (rst || !seen_rst)
        load |=> word == $past(load_word)); // R5
    AST_IDLE_HOLDS: assert property (@(posedge clk) disable iff (rst || !seen_rst)
        (!en && !load) |=> $stable(word)); // R6
    AST_WRAP_TO_ZERO: assert property (@(posedge clk) disable iff (rst || !seen_rst)
        word == MSB_ONLY |-> next_word == '0); // R7
    AST_EVEN_FLIPS_LSB: assert property (@(posedge clk) disable iff (rst || !seen_rst)
        !(^word) |-> next_word[0] != word[0]); // R9

endmodule

bind gray_step_counter gray_step_counter_chk #(.WIDTH(WIDTH)) u_chk (
    .clk       (clk),
    .rst       (rst),
    .en        (en),
    .load      (load),
    .load_word (load_word),
    .word      (word),
    .next_word (next_word)
);

// File: tb/test_gray_step_counter.sv
`timescale 1ns/1ps
module test_gray_step_counter;

    localparam int W = 3;
    localparam int N = 1 << W;

    logic         clk = 1'b0;
    logic         rst = 1'b1;
    logic         en = 1'b0;
    logic         load = 1'b0;
    logic [W-1:0] load_word = '0;
    logic [W-1:0] word;
    logic [W-1:0] next_word;

    int vectors = 0;
    int miscompares = 0;
    logic [W-1:0] exp_word = '0;

    always #10 clk = ~clk;

    gray_step_counter #(.WIDTH(W)) i_gray_step_counter (
        .clk(clk), .rst(rst), .en(en), .load(load),
        .load_word(load_word), .word(word), .next_word(next_word)
    );

    // Reference successor through binary: decode, add one, encode.
    function automatic logic [W-1:0] ref_succ(input logic [W-1:0] g);
        logic [W-1:0] b;
        b[W-1] = g[W-1];
        for (int i = W - 2; i >= 0; i--) b[i] = b[i+1] ^ g[i];
        b = b + 1'b1;
        return b ^ (b >> 1);
    endfunction

    task automatic check(input bit ok, input string req,
                         input logic [W-1:0] act, input logic [W-1:0] expv);
        vectors++;
        if (!ok) begin
            miscompares++;
            $display("FAIL %s actual=%b expected=%b", req, act, expv);
        end
    endtask

    // One clock: drive at the falling edge, check the successor, check word after the edge.
    task automatic cycle(input logic r, input logic e, input logic l, input logic [W-1:0] lw);
        @(negedge clk);
        rst = r; en = e; load = l; load_word = lw;
        #1;
        if (!$isunknown(word)) begin
            check(next_word == ref_succ(word), "R2", next_word, ref_succ(word));
            check($countones(word ^ next_word) == 1, "R3", word ^ next_word, '0);
        end
        if (r)      exp_word = '0;
        else if (l) exp_word = lw;
        else if (e) exp_word = ref_succ(exp_word);
        @(posedge clk);
        #1;
        if (r)      check(word == exp_word, "R1", word, exp_word);
        else if (l) check(word == exp_word, "R5", word, exp_word);
        else if (e) check(word == exp_word, "R4", word, exp_word);
        else        check(word == exp_word, "R6", word, exp_word);
    endtask

    initial begin
        #2000000;
        miscompares++;
        $display("FAIL watchdog actual=%0d expected=%0d", vectors, 0);
        $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
        $finish;
    end

    initial begin
        logic [W-1:0] seq3 [N];
        logic [N-1:0] seen;
        logic [W-1:0] prev;
        seq3[0] = 3'b000; seq3[1] = 3'b001; seq3[2] = 3'b011; seq3[3] = 3'b010;
        seq3[4] = 3'b110; seq3[5] = 3'b111; seq3[6] = 3'b101; seq3[7] = 3'b100;
        void'($urandom(32'd7071));

        // R1: reset with en and load high still clears
        cycle(1'b1, 1'b1, 1'b1, 3'b101);
        cycle(1'b1, 1'b0, 1'b0, 3'b000);
        check(word == '0, "R1", word, '0);

        // R2 / R8: full cycle against the listed sequence, each word once
        seen = '0;
        for (int k = 0; k < N; k++) begin
            check(word == seq3[k], "R2", word, seq3[k]);
            seen[word] = 1'b1;
            prev = word;
            cycle(1'b0, 1'b1, 1'b0, 3'b000);
            check($countones(word ^ prev) == 1, "R3", word ^ prev, '0);
        end
        check(seen == {N{1'b1}}, "R8", W'(seen), '1);
        check(word == '0, "R8", word, '0);

        // R5: load wins over en
        cycle(1'b0, 1'b1, 1'b1, 3'b011);
        check(word == 3'b011, "R5", word, 3'b011);

        // R6: idle holds for several cycles
        for (int k = 0; k < 3; k++) cycle(1'b0, 1'b0, 1'b0, 3'b110);
        check(word == 3'b011, "R6", word, 3'b011);

        // R7: wrap from MSB-only word
        cycle(1'b0, 1'b0, 1'b1, 3'b100);
        #1 check(next_word == 3'b000, "R7", next_word, 3'b000);
        cycle(1'b0, 1'b1, 1'b0, 3'b000);
        check(word == 3'b000, "R7", word, 3'b000);

        // R9: flip position for every possible word
        for (int v = 0; v < N; v++) begin
            cycle(1'b0, 1'b0, 1'b1, W'(v));
            #1;
            if (!(^word)) check((word ^ next_word) == 3'b001, "R9", word ^ next_word, 3'b001);
            else          check((word ^ next_word) == ((word & (~word + 1'b1)) == 3'b100 ? 3'b100
                                                      : W'((word & (~word + 1'b1)) << 1)),
                                "R9", word ^ next_word, ref_succ(word) ^ word);
        end

        // Random mix
        for (int k = 0; k < 400; k++) begin
            logic [7:0] r8;
            r8 = 8'($urandom);
            cycle(r8 < 8'd6, r8[1] | r8[2], r8[7] & r8[6], W'($urandom));
        end

        $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
        $finish;
    end

endmodule